// File: doc/BRIEF.md
# Zero-Crossing BPSK Phase Modulator

This block is the phase-generation core of a binary phase-shift keyed synthesizer. It runs two phase accumulators from one clock. The carrier accumulator produces the output phase. A 14-bit phase offset is added to that phase, and the offset is taken from one of two stored profiles, mark or space, according to the `profSel` input. The second accumulator is the trigger channel. Its tuning word holds a single set bit, placed at the position of the lowest set bit of the carrier tuning word, so it wraps once per carrier repetition period. The most significant bit of the trigger phase forms a square wave, `trigOut`.

A change on `profSel` is not applied at once. The core registers the trigger square wave into its own clock domain and detects its rising edge. Only on that update does it load the selected offset. Every phase flip therefore lands at the same carrier phase state. The latency from a select change to the flip varies and can span many carrier cycles. The trigger channel has its own phase offset. Adjusting that offset moves the flip point, which compensates for downstream pipeline delay.

Software loads the tuning words and offsets through a small write port into staging registers. It then issues `accClear`, which starts both accumulators from zero on the same edge and makes the staged settings active.

Top module: `zcb_mod_top`

## Requirements
- R1: On every clock edge without a clear, the carrier accumulator adds the active carrier tuning word, modulo 2^32. `carPhase` equals bits 31:16 of the sum of that accumulator and the active offset shifted left by 18.
- R2: The offset is a 14-bit word placed at bits 31:18 of the phase. With `profSel`=1 the mark offset is used; its reset value is 0x2000, a half turn that adds 0x8000 to `carPhase`. With `profSel`=0 the space offset is used; its reset value is 0.
- R3: The trigger accumulator adds its own active tuning word on every edge. `trigOut` is bit 31 of the sum of the trigger accumulator and the trigger offset shifted left by 18.
- R4: A rising edge of `trigOut` passes through two register stages. The offset selected by `profSel` shows in `carPhase` right after the second clock edge that follows the edge that raised `trigOut`. With matched tuning words, every flip therefore happens at the same carrier phase. With both words at 0x00800000 and a trigger offset of 0, the un-offset carrier phase on the flipped cycle is 0x8100.
- R5: A change of `profSel` has no effect on `carPhase` until the next update. The value of `profSel` at the update edge decides the offset.
- R6: At most one offset change takes effect per trigger rising edge. Consecutive phase flips are at least one trigger period apart, and the offset is held between updates.
- R7: `accClear` zeroes both accumulators on the same edge. It also resets the trigger edge detector, loads all staged settings, and applies the current `profSel`.
- R8: With `cfgWe`=1, `cfgAddr` selects the staging register that `cfgData` writes. Address 0 is the carrier tuning word, 1 the trigger tuning word, 2 the mark offset in [13:0], 3 the space offset in [13:0], and 4 the trigger offset in [13:0]. Other addresses are ignored. Written values take effect only at a clear or an update.
- R9: After reset, both tuning words, both accumulators, the space offset and the trigger offset are zero, and the mark offset is 0x2000. `carPhase` and `trigOut` are 0.
- R10: A trigger offset k moves the trigger rise, and so the flip, earlier by k·2^18 of trigger phase. With 0x00800000 tuning words and k=0x1000, the flip point moves from carrier phase 0x8100 to 0x4100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 3 | Staging register address |
| cfgData | input | 32 | Write data |
| accClear | input | 1 | Synchronous clear of both accumulators; loads staged settings |
| profSel | input | 1 | Profile select: 1 mark, 0 space |
| carPhase | output | 16 | Top bits of the offset carrier phase |
| trigOut | output | 1 | Trigger square wave (trigger phase MSB) |

## Verification
The hardest situation to reach is a flip landing at an exact, predictable carrier phase. The select change must fall between trigger edges, and the trigger offset must be changed without itself producing a spurious switch. The stimulus clears both channels with identical tuning words, waits for a trigger rise, and then moves `profSel`. It detects each flip at the ports as a step in `carPhase` that differs from the nominal increment, and compares the un-offset phase at that step with the value worked out from the trigger geometry. The same comparison is repeated after a new trigger offset has been loaded by an update. Toggling the select on every cycle shows that flips never come closer together than one trigger period.

// File: rtl/zcb_pkg.sv
package zcb_pkg;

  typedef struct packed {
    logic clrAcc;     // zero both accumulators
    logic loadCfg;    // copy staging registers to active
    logic applyProf;  // load selected offset
  } zcbStrobes_t;

  localparam logic [2:0] ADDR_CAR_FTW = 3'd0;
  localparam logic [2:0] ADDR_TRG_FTW = 3'd1;
  localparam logic [2:0] ADDR_MARK    = 3'd2;
  localparam logic [2:0] ADDR_SPACE   = 3'd3;
  localparam logic [2:0] ADDR_TRG_POW = 3'd4;

endpackage

// File: rtl/zcb_phase_acc.sv
module zcb_phase_acc #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ACC_W-1:0] ftw,
  input  logic [OFS_W-1:0] ofs,
  output logic [ACC_W-1:0] accOut,
  output logic [ACC_W-1:0] phaseOut
);
  localparam int PAD_W = ACC_W - OFS_W;

  logic [ACC_W-1:0] accQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   accQ <= '0;
    else if (clr) accQ <= '0;
    else          accQ <= accQ + ftw;
  end

  assign accOut   = accQ;
  assign phaseOut = accQ + {ofs, {PAD_W{1'b0}}};
endmodule

// File: rtl/zcb_ctrl.sv
module zcb_ctrl
  import zcb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accClear,
  input  logic        trigMsb,
  output zcbStrobes_t strobes
);
  logic trgSync;
  logic trgPrev;
  logic updPulse;

  // two-stage capture of the trigger square wave into the core domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trgSync <= 1'b0;
      trgPrev <= 1'b0;
    end else if (accClear) begin
      trgSync <= 1'b0;
      trgPrev <= 1'b0;
    end else begin
      trgSync <= trigMsb;
      trgPrev <= trgSync;
    end
  end

  assign updPulse = trgSync & ~trgPrev;

  always_comb begin
    strobes           = '0;
    strobes.clrAcc    = accClear;
    strobes.loadCfg   = accClear | updPulse;
    strobes.applyProf = accClear | updPulse;
  end

  // R4: an update only follows a captured high trigger level
  assert_update_from_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    updPulse |-> ($past(trigMsb) && !$past(accClear)));

  // R6: never two updates back to back
  assert_single_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    updPulse |=> !updPulse);
endmodule

// File: rtl/zcb_datapath.sv
module zcb_datapath
  import zcb_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int OFS_W  = 14,
  parameter int OUT_W  = 16,
  parameter int ADDR_W = 3,
  parameter logic [OFS_W-1:0] MARK_RST = 14'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [ACC_W-1:0]  cfgData,
  input  logic              profSel,
  input  zcbStrobes_t       strobes,
  output logic [OUT_W-1:0]  carPhase,
  output logic              trigMsb
);
  logic [ACC_W-1:0] carFtwStg, trgFtwStg;
  logic [OFS_W-1:0] markStg, spaceStg, trgPowStg;
  logic [ACC_W-1:0] carFtwAct, trgFtwAct;
  logic [OFS_W-1:0] trgPowAct, ofsAct;
  logic [ACC_W-1:0] carAcc, trgAcc, carPhaseFull, trgPhaseFull;

  // staging registers written by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carFtwStg <= '0;
      trgFtwStg <= '0;
      markStg   <= MARK_RST;
      spaceStg  <= '0;
      trgPowStg <= '0;
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_CAR_FTW: carFtwStg <= cfgData;
        ADDR_TRG_FTW: trgFtwStg <= cfgData;
        ADDR_MARK:    markStg   <= cfgData[OFS_W-1:0];
        ADDR_SPACE:   spaceStg  <= cfgData[OFS_W-1:0];
        ADDR_TRG_POW: trgPowStg <= cfgData[OFS_W-1:0];
        default: ;
      endcase
    end
  end

  // active settings change only on a clear or an update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carFtwAct <= '0;
      trgFtwAct <= '0;
      trgPowAct <= '0;
      ofsAct    <= '0;
    end else begin
      if (strobes.loadCfg) begin
        carFtwAct <= carFtwStg;
        trgFtwAct <= trgFtwStg;
        trgPowAct <= trgPowStg;
      end
      if (strobes.applyProf) ofsAct <= profSel ? markStg : spaceStg;
    end
  end

  zcb_phase_acc #(.ACC_W(ACC_W), .OFS_W(OFS_W)) u_carAcc (
    .clk(clk), .rst_n(rst_n), .clr(strobes.clrAcc), .ftw(carFtwAct),
    .ofs(ofsAct), .accOut(carAcc), .phaseOut(carPhaseFull));

  zcb_phase_acc #(.ACC_W(ACC_W), .OFS_W(OFS_W)) u_trgAcc (
    .clk(clk), .rst_n(rst_n), .clr(strobes.clrAcc), .ftw(trgFtwAct),
    .ofs(trgPowAct), .accOut(trgAcc), .phaseOut(trgPhaseFull));

  assign carPhase = carPhaseFull[ACC_W-1 -: OUT_W];
  assign trigMsb  = trgPhaseFull[ACC_W-1];

  // R7: both accumulators start together from zero
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clrAcc |=> (carAcc == '0 && trgAcc == '0));

  // R6: offset held between updates
  assert_offset_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.applyProf |=> $stable(ofsAct));
endmodule

// File: rtl/zcb_mod_top.sv
module zcb_mod_top
  import zcb_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int OFS_W  = 14,
  parameter int OUT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [ACC_W-1:0]  cfgData,
  input  logic              accClear,
  input  logic              profSel,
  output logic [OUT_W-1:0]  carPhase,
  output logic              trigOut
);
  localparam logic [OFS_W-1:0] MARK_RST = OFS_W'(1) << (OFS_W - 1);

  zcbStrobes_t strobes;
  logic        trigMsb;

  zcb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accClear(accClear),
    .trigMsb(trigMsb), .strobes(strobes));

  zcb_datapath #(
    .ACC_W(ACC_W), .OFS_W(OFS_W), .OUT_W(OUT_W), .ADDR_W(ADDR_W),
    .MARK_RST(MARK_RST)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .profSel(profSel), .strobes(strobes),
    .carPhase(carPhase), .trigMsb(trigMsb));

  assign trigOut = trigMsb;
endmodule

// File: tb/zcb_mod_top_tb.sv
module zcb_mod_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        accClear = 1'b0;
  logic        profSel = 1'b0;
  logic [15:0] carPhase;
  logic        trigOut;

  always #4 clk = ~clk;

  zcb_mod_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .accClear(accClear), .profSel(profSel),
    .carPhase(carPhase), .trigOut(trigOut));

  int errors = 0;
  int checks = 0;
  string curTag = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mCar, mTrg, mCarFtw, mTrgFtw, sCarFtw, sTrgFtw;
  logic [13:0] mOfs, mPow, sMark, sSpace, sPow;
  bit          mSync, mPrev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCar = 0; mTrg = 0; mCarFtw = 0; mTrgFtw = 0; sCarFtw = 0; sTrgFtw = 0;
      mOfs = 0; mPow = 0; sMark = 14'h2000; sSpace = 0; sPow = 0;
      mSync = 0; mPrev = 0;
    end else begin
      logic [31:0] tp;
      bit tbit, upd;
      tp   = mTrg + {mPow, 18'b0};
      tbit = tp[31];
      upd  = mSync && !mPrev;
      mCar = accClear ? 32'd0 : mCar + mCarFtw;
      mTrg = accClear ? 32'd0 : mTrg + mTrgFtw;
      mPrev = accClear ? 1'b0 : mSync;
      mSync = accClear ? 1'b0 : tbit;
      if (accClear || upd) begin
        mCarFtw = sCarFtw; mTrgFtw = sTrgFtw; mPow = sPow;
        mOfs = profSel ? sMark : sSpace;
      end
      if (cfgWe) begin
        case (cfgAddr)
          3'd0: sCarFtw = cfgData;
          3'd1: sTrgFtw = cfgData;
          3'd2: sMark = cfgData[13:0];
          3'd3: sSpace = cfgData[13:0];
          3'd4: sPow = cfgData[13:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] expPhase();
    logic [31:0] s;
    s = mCar + {mOfs, 18'b0};
    return s[31:16];
  endfunction

  function automatic bit expTrig();
    logic [31:0] s;
    s = mTrg + {mPow, 18'b0};
    return s[31];
  endfunction

  // port-level flip tracking
  bit          running = 0, tracking = 0;
  int          skip = 0, cyc = 0;
  logic [15:0] prevPhase = '0, expStep = '0;
  int          jumpCyc[$];
  logic [15:0] jumpBase[$];

  always @(negedge clk) begin
    if (rst_n && running) begin
      logic [15:0] ep, d;
      ep = expPhase();
      check(carPhase == ep, curTag, "carPhase vs model", carPhase, ep);
      check(trigOut == expTrig(), "R3", "trigOut vs model", trigOut, expTrig());
      d = carPhase - prevPhase;
      if (tracking && skip == 0 && d != expStep) begin
        jumpCyc.push_back(cyc);
        jumpBase.push_back(prevPhase + expStep);
        check(d == expStep + 16'h8000, "R2", "half-turn flip size", d, expStep + 16'h8000);
      end
      if (skip > 0) skip--;
      prevPhase = carPhase;
      cyc++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1 cfgWe = 1; cfgAddr = a; cfgData = d;
    @(posedge clk); #1 cfgWe = 0;
  endtask

  task automatic doClear();
    @(posedge clk); #1 accClear = 1; skip = 3;
    @(posedge clk); #1 accClear = 0;
  endtask

  task automatic setSel(input bit v);
    @(posedge clk); #1 profSel = v;
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int j0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1; running = 1;
    @(negedge clk);
    check(carPhase == 0 && trigOut == 0, "R9", "reset outputs", {carPhase, 7'b0, trigOut}, 0);

    // R8: staged writes have no effect before clear
    wr(3'd0, 32'h0080_0000);
    wr(3'd1, 32'h0080_0000);
    repeat (5) @(negedge clk);
    check(carPhase == 0, "R8", "staged tuning word not active", carPhase, 0);

    // R7: clear starts both channels at zero
    @(posedge clk); #1 accClear = 1; skip = 3;
    @(posedge clk); #1 accClear = 0;
    @(negedge clk);
    check(carPhase == 0 && trigOut == 0, "R7", "phase after clear", carPhase, 0);
    expStep = 16'h0080; tracking = 1;

    // R5: select change waits for the next update
    curTag = "R5";
    while (trigOut !== 1'b1) @(negedge clk);
    repeat (10) @(negedge clk);
    j0 = jumpCyc.size();
    setSel(1);
    repeat (50) @(negedge clk);
    check(jumpCyc.size() == j0, "R5", "no flip before update", jumpCyc.size(), j0);
    repeat (600) @(negedge clk);
    check(jumpCyc.size() == j0 + 1, "R5", "one flip at update", jumpCyc.size(), j0 + 1);
    if (jumpCyc.size() > j0)
      check(jumpBase[j0] == 16'h8100, "R4", "flip carrier phase", jumpBase[j0], 16'h8100);

    // R4: repeated flips land on the same carrier phase
    curTag = "R4";
    j0 = jumpCyc.size();
    setSel(0); repeat (600) @(negedge clk);
    setSel(1); repeat (600) @(negedge clk);
    check(jumpCyc.size() == j0 + 2, "R4", "two flips", jumpCyc.size(), j0 + 2);
    if (jumpCyc.size() >= j0 + 2) begin
      check(16'(jumpBase[j0] - 16'h8000) == 16'h8100, "R4", "mark-to-space phase",
            16'(jumpBase[j0] - 16'h8000), 16'h8100);
      check(jumpBase[j0+1] == 16'h8100, "R4", "space-to-mark phase", jumpBase[j0+1], 16'h8100);
    end

    // R6: toggling every cycle yields flips at least one period apart
    curTag = "R6";
    j0 = jumpCyc.size();
    for (int i = 0; i < 2048; i++) setSel(i[0]);
    setSel(1);
    repeat (600) @(negedge clk);
    for (int i = j0 + 1; i < jumpCyc.size(); i++)
      check(jumpCyc[i] - jumpCyc[i-1] >= 512, "R6", "flip spacing",
            jumpCyc[i] - jumpCyc[i-1], 512);
    check(jumpCyc.size() - j0 <= 6, "R6", "flip count bound", jumpCyc.size() - j0, 6);

    // R10: trigger offset moves the flip point by a quarter turn
    curTag = "R10";
    wr(3'd4, 32'h0000_1000);
    repeat (600) @(negedge clk);
    j0 = jumpCyc.size();
    setSel(0);
    repeat (600) @(negedge clk);
    check(jumpCyc.size() == j0 + 1, "R10", "flip after offset change", jumpCyc.size(), j0 + 1);
    if (jumpCyc.size() > j0)
      check(16'(jumpBase[j0] - 16'h8000) == 16'h4100, "R10", "shifted flip phase",
            16'(jumpBase[j0] - 16'h8000), 16'h4100);

    // R1: second pattern with custom mark and an ignored address
    curTag = "R1";
    tracking = 0;
    wr(3'd0, 32'h0360_0000);
    wr(3'd1, 32'h0020_0000);
    wr(3'd2, 32'h0000_1000);
    wr(3'd4, 32'h0000_0000);
    wr(3'd6, 32'hFFFF_FFFF);
    doClear();
    repeat (3000) @(negedge clk);
    setSel(1); repeat (3000) @(negedge clk);
    setSel(0); repeat (2500) @(negedge clk);
    setSel(1); repeat (2500) @(negedge clk);
    check(carPhase == expPhase(), "R1", "final phase", carPhase, expPhase());

    finishRun();
  end
endmodule